// File: doc/BRIEF.md
# Paged Address Translation Unit

This block sits between a processor's load, store and instruction-fetch port and the memory system. It turns a virtual address into a physical address using 1 KB pages: the low offset bits pass straight through, and the virtual page number selects a page table entry. That entry supplies the physical page number, a valid bit and access rights. An eight-entry fully associative translation cache answers most requests in one cycle. On a miss, a hardware walker reads one entry of a single-level table from physical memory, at an address formed from a base register and the page number. It then completes the access and refills the cache.

Every access is checked against the entry's valid bit and rights. A non-resident page gives a page fault. An operation the rights do not allow gives a protection fault. Writing the base register selects another process's table and discards every cached translation.

Top module: `paged_xlat`

## Requirements
- R1: A translated physical address is the entry's physical page number in bits [PA_W-1:10] followed by the request's offset bits [9:0], which are unchanged.
- R2: On a miss the block issues exactly one single-cycle read on the memory port, at address base + vpn * 2, where vpn is virtual address bits [VA_W-1:10].
- R3: A table entry is 16 bits: bit 15 valid, bit 14 execute, bit 13 write, bit 12 read, bits [9:0] physical page number. Bits 11:10 are ignored.
- R4: A request that hits the translation cache is answered on the cycle after acceptance, with no memory read.
- R5: An entry with bit 15 clear gives a page fault with physical address 0. The entry is not cached, so a retry of that page walks the table again.
- R6: Operation code req_op_i: 2'b00 load needs read, 2'b01 store needs write, 2'b1x fetch needs execute. A valid page without the needed right gives a protection fault with physical address 0.
- R7: Valid entries are cached together with their rights, so a later access that violates them faults from the cache without a memory read.
- R8: Writing the base register empties the translation cache, and no request is accepted in the cycle of the write. Later misses use the new base.
- R9: Refills use round-robin slot order, starting at slot 0 after reset and after each base write. The ninth distinct page installed evicts the first one.
- R10: After reset req_ready_o is 1 and rsp_valid_o and mem_req_o are 0. req_ready_o stays 0 from a miss's acceptance until its response, and each accepted request gets exactly one response.
- R11: If the base register is written while a walk is in flight, the walk still returns its response, but its entry is not installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_we_i | input | 1 | Write strobe for the table base register |
| base_i | input | PA_W | New table base (physical byte address) |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_vaddr_i | input | VA_W | Virtual address |
| req_op_i | input | 2 | Operation: load, store or fetch |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_paddr_o | output | PA_W | Physical address, 0 on a fault |
| rsp_page_fault_o | output | 1 | Page not resident |
| rsp_prot_fault_o | output | 1 | Access rights violated |
| mem_req_o | output | 1 | Table entry read request (one cycle) |
| mem_addr_o | output | PA_W | Table entry byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | PTE_W | Table entry read data |

## Verification
Assertions watch every cycle for the following: no two cache slots matching one page, no hit in the cycle after a base write, a response on the cycle after any hit, a single-cycle memory read per walk, ready dropping after a miss is accepted, and faults that are exclusive and carry a zero address. Whether an address, fault or rights decision is right for a given table only shows in the bench's scenarios. The same holds for round-robin eviction, the address the walker forms, the repeated walk for an invalid page, and the dropped refill after a base write in the middle of a walk. The bench checks these against its own copy of the table.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
  localparam int RIGHTS_W = 3;

  // bit order matches the entry layout: [2]=exec, [1]=write, [0]=read
  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } rights_t;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_ISSUE = 2'd1,
    W_WAIT  = 2'd2
  } walk_state_e;
endpackage

// File: rtl/xlat_perm.sv
`timescale 1ns/1ps
module xlat_perm
  import xlat_pkg::*;
(
  input  logic [1:0]          op_i,
  input  logic                valid_i,
  input  logic [RIGHTS_W-1:0] rights_i,
  output logic                page_fault_o,
  output logic                prot_fault_o
);
  rights_t rts;
  logic    allowed;

  assign rts = rights_t'(rights_i);

  always_comb begin
    if (op_i[1])      allowed = rts.x;
    else if (op_i[0]) allowed = rts.w;
    else              allowed = rts.r;
  end

  assign page_fault_o = !valid_i;
  assign prot_fault_o = valid_i && !allowed;
endmodule

// File: rtl/xlat_tlb.sv
`timescale 1ns/1ps
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 10,
  parameter int PPN_W   = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic [VPN_W-1:0]    lk_vpn_i,
  output logic                lk_hit_o,
  output logic [PPN_W-1:0]    lk_ppn_o,
  output logic [RIGHTS_W-1:0] lk_rights_o,
  input  logic                ins_i,
  input  logic [VPN_W-1:0]    ins_vpn_i,
  input  logic [PPN_W-1:0]    ins_ppn_i,
  input  logic [RIGHTS_W-1:0] ins_rights_i
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0]  used_q;
  logic [ENTRIES-1:0]  hit_vec;
  logic [VPN_W-1:0]    tag_q    [ENTRIES];
  logic [PPN_W-1:0]    ppn_q    [ENTRIES];
  logic [RIGHTS_W-1:0] rights_q [ENTRIES];
  logic [IDX_W-1:0]    victim_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = used_q[g] && (tag_q[g] == lk_vpn_i);
  end

  assign lk_hit_o = |hit_vec;

  always_comb begin
    lk_ppn_o    = '0;
    lk_rights_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        lk_ppn_o    = ppn_q[i];
        lk_rights_o = rights_q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q   <= '0;
      victim_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]    <= '0;
        ppn_q[i]    <= '0;
        rights_q[i] <= '0;
      end
    end else if (flush_i) begin
      used_q   <= '0;
      victim_q <= '0;
    end else if (ins_i) begin
      used_q[victim_q]   <= 1'b1;
      tag_q[victim_q]    <= ins_vpn_i;
      ppn_q[victim_q]    <= ins_ppn_i;
      rights_q[victim_q] <= ins_rights_i;
      victim_q           <= (victim_q == LAST) ? '0 : victim_q + 1'b1;
    end
  end

  assert_single_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  assert_flush_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !lk_hit_o);
endmodule

// File: rtl/xlat_walker.sv
`timescale 1ns/1ps
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int PA_W  = 20,
  parameter int VPN_W = 10,
  parameter int PPN_W = 10,
  parameter int PTE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [VPN_W-1:0]    vpn_i,
  input  logic [PA_W-1:0]     base_i,
  input  logic                base_we_i,
  output logic                idle_o,
  output logic                mem_req_o,
  output logic [PA_W-1:0]     mem_addr_o,
  input  logic                mem_rvalid_i,
  input  logic [PTE_W-1:0]    mem_rdata_i,
  output logic                done_o,
  output logic                done_fresh_o,
  output logic                pte_valid_o,
  output logic [RIGHTS_W-1:0] pte_rights_o,
  output logic [PPN_W-1:0]    pte_ppn_o
);
  localparam int ENT_SHIFT = $clog2(PTE_W / 8);
  localparam int V_BIT     = PTE_W - 1;
  localparam int R_TOP     = PTE_W - 2;

  walk_state_e state_q;
  logic        stale_q;

  assign idle_o     = (state_q == W_IDLE);
  assign mem_req_o  = (state_q == W_ISSUE);
  assign mem_addr_o = base_i + (PA_W'(vpn_i) << ENT_SHIFT);
  assign done_o     = (state_q == W_WAIT) && mem_rvalid_i;
  assign done_fresh_o = !stale_q;

  assign pte_valid_o  = mem_rdata_i[V_BIT];
  assign pte_rights_o = mem_rdata_i[R_TOP -: RIGHTS_W];
  assign pte_ppn_o    = mem_rdata_i[PPN_W-1:0];

  // reserved entry bits carry no meaning
  if (R_TOP - RIGHTS_W >= PPN_W) begin : g_rsvd
    logic unused_rsvd;
    assign unused_rsvd = ^mem_rdata_i[R_TOP-RIGHTS_W:PPN_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= W_IDLE;
      stale_q <= 1'b0;
    end else begin
      unique case (state_q)
        W_IDLE: if (start_i) begin
          state_q <= W_ISSUE;
          stale_q <= 1'b0;
        end
        W_ISSUE: begin
          state_q <= W_WAIT;
          if (base_we_i) stale_q <= 1'b1;
        end
        W_WAIT: begin
          if (mem_rvalid_i) state_q <= W_IDLE;
          if (base_we_i)    stale_q <= 1'b1;
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end

  assert_one_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  assert_start_only_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> idle_o);
endmodule

// File: rtl/paged_xlat.sv
`timescale 1ns/1ps
module paged_xlat
  import xlat_pkg::*;
#(
  parameter int VA_W        = 20,
  parameter int PA_W        = 20,
  parameter int OFF_W       = 10,
  parameter int PTE_W       = 16,
  parameter int TLB_ENTRIES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             base_we_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [1:0]       req_op_i,
  output logic             rsp_valid_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             rsp_page_fault_o,
  output logic             rsp_prot_fault_o,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [PTE_W-1:0] mem_rdata_i
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;

  logic [PA_W-1:0]     base_q;
  logic [VPN_W-1:0]    vpn_q;
  logic [OFF_W-1:0]    off_q;
  logic [1:0]          op_q;

  logic                walk_idle, walk_done, walk_fresh;
  logic                pte_valid;
  logic [RIGHTS_W-1:0] pte_rights;
  logic [PPN_W-1:0]    pte_ppn;

  logic                lk_hit;
  logic [PPN_W-1:0]    lk_ppn;
  logic [RIGHTS_W-1:0] lk_rights;

  logic                hit_pf, hit_prf, walk_pf, walk_prf;
  logic                accept, hit_acc, miss_acc, install;

  // no acceptance while the base changes: the lookup would see stale entries
  assign req_ready_o = walk_idle && !base_we_i;
  assign accept      = req_valid_i && req_ready_o;
  assign hit_acc     = accept && lk_hit;
  assign miss_acc    = accept && !lk_hit;
  assign install     = walk_done && pte_valid && walk_fresh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) base_q <= '0;
    else if (base_we_i) base_q <= base_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vpn_q <= '0;
      off_q <= '0;
      op_q  <= '0;
    end else if (miss_acc) begin
      vpn_q <= req_vaddr_i[VA_W-1:OFF_W];
      off_q <= req_vaddr_i[OFF_W-1:0];
      op_q  <= req_op_i;
    end
  end

  xlat_tlb #(
    .ENTRIES (TLB_ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W)
  ) u_tlb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (base_we_i),
    .lk_vpn_i     (req_vaddr_i[VA_W-1:OFF_W]),
    .lk_hit_o     (lk_hit),
    .lk_ppn_o     (lk_ppn),
    .lk_rights_o  (lk_rights),
    .ins_i        (install),
    .ins_vpn_i    (vpn_q),
    .ins_ppn_i    (pte_ppn),
    .ins_rights_i (pte_rights)
  );

  xlat_walker #(
    .PA_W  (PA_W),
    .VPN_W (VPN_W),
    .PPN_W (PPN_W),
    .PTE_W (PTE_W)
  ) u_walker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (miss_acc),
    .vpn_i        (vpn_q),
    .base_i       (base_q),
    .base_we_i    (base_we_i),
    .idle_o       (walk_idle),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .done_o       (walk_done),
    .done_fresh_o (walk_fresh),
    .pte_valid_o  (pte_valid),
    .pte_rights_o (pte_rights),
    .pte_ppn_o    (pte_ppn)
  );

  xlat_perm u_perm_hit (
    .op_i         (req_op_i),
    .valid_i      (1'b1),
    .rights_i     (lk_rights),
    .page_fault_o (hit_pf),
    .prot_fault_o (hit_prf)
  );

  xlat_perm u_perm_walk (
    .op_i         (op_q),
    .valid_i      (pte_valid),
    .rights_i     (pte_rights),
    .page_fault_o (walk_pf),
    .prot_fault_o (walk_prf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o      <= 1'b0;
      rsp_paddr_o      <= '0;
      rsp_page_fault_o <= 1'b0;
      rsp_prot_fault_o <= 1'b0;
    end else if (hit_acc) begin
      rsp_valid_o      <= 1'b1;
      rsp_paddr_o      <= (hit_pf || hit_prf) ? '0 : {lk_ppn, req_vaddr_i[OFF_W-1:0]};
      rsp_page_fault_o <= hit_pf;
      rsp_prot_fault_o <= hit_prf;
    end else if (walk_done) begin
      rsp_valid_o      <= 1'b1;
      rsp_paddr_o      <= (walk_pf || walk_prf) ? '0 : {pte_ppn, off_q};
      rsp_page_fault_o <= walk_pf;
      rsp_prot_fault_o <= walk_prf;
    end else begin
      rsp_valid_o      <= 1'b0;
      rsp_page_fault_o <= 1'b0;
      rsp_prot_fault_o <= 1'b0;
    end
  end

  assert_hit_next_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_acc |=> rsp_valid_o && !mem_req_o);

  assert_miss_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_acc |=> !req_ready_o);

  assert_fault_zero_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_page_fault_o || rsp_prot_fault_o) |-> (rsp_valid_o && rsp_paddr_o == '0));

  assert_fault_exclusive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_page_fault_o && rsp_prot_fault_o));
endmodule

// File: tb/paged_xlat_tb.sv
`timescale 1ns/1ps
module paged_xlat_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [19:0] base_v = '0;
  logic        req_valid = 1'b0;
  logic [19:0] req_vaddr = '0;
  logic [1:0]  req_op = '0;
  logic        req_ready;
  logic        rsp_valid;
  logic [19:0] rsp_paddr;
  logic        rsp_pf, rsp_prf;
  logic        mem_req;
  logic [19:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  paged_xlat u_dut (
    .clk_i (clk), .rst_ni (rst_n),
    .base_we_i (base_we), .base_i (base_v),
    .req_valid_i (req_valid), .req_ready_o (req_ready),
    .req_vaddr_i (req_vaddr), .req_op_i (req_op),
    .rsp_valid_o (rsp_valid), .rsp_paddr_o (rsp_paddr),
    .rsp_page_fault_o (rsp_pf), .rsp_prot_fault_o (rsp_prf),
    .mem_req_o (mem_req), .mem_addr_o (mem_addr),
    .mem_rvalid_i (mem_rvalid), .mem_rdata_i (mem_rdata)
  );

  typedef struct {
    logic [19:0] paddr;
    logic        pf;
    logic        prf;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [15:0] pt [int];
  int          n_cmp = 0, n_bad = 0;
  int          walks = 0;
  int          last_addr = 0;
  bit          pend = 0;
  int          dly = 0;
  int          pend_addr = 0;
  bit          reported = 0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  endtask

  // table memory: two-cycle latency after the request cycle
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      walks++;
      last_addr = int'(mem_addr);
      pend_addr = int'(mem_addr);
      pend <= 1'b1;
      dly  <= 1;
    end else if (pend) begin
      if (dly == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= pt.exists(pend_addr) ? pt[pend_addr] : 16'h0;
        pend <= 1'b0;
      end else dly <= dly - 1;
    end
  end

  function automatic exp_t model(input logic [19:0] va, input logic [1:0] op);
    exp_t e;
    int a;
    logic [15:0] p;
    bit ok;
    a = int'(base_v) + int'(va[19:10]) * 2;
    p = pt.exists(a) ? pt[a] : 16'h0;
    if (op[1]) ok = p[14];
    else if (op[0]) ok = p[13];
    else ok = p[12];
    e.pf  = !p[15];
    e.prf = p[15] && !ok;
    e.paddr = (e.pf || e.prf) ? 20'h0 : {p[9:0], va[9:0]};
    return e;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) begin
        check(0, "R10 response without request", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(rsp_paddr == e.paddr && rsp_pf == e.pf && rsp_prf == e.prf,
              e.tag, int'({rsp_pf, rsp_prf, rsp_paddr}), int'({e.pf, e.prf, e.paddr}));
      end
    end
  end

  task automatic do_req(input logic [19:0] va, input logic [1:0] op, input bit miss,
                        input string tag);
    exp_t e;
    int w0, n;
    e = model(va, op);
    e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    w0 = walks;
    req_valid = 1'b1; req_vaddr = va; req_op = op;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    if (miss) check(req_ready == 1'b0, {tag, " R10 ready low in walk"}, int'(req_ready), 0);
    n = 0;
    while (!rsp_valid) begin @(negedge clk); n++; end
    if (!miss) check(n == 0, {tag, " R4 hit latency"}, n, 0);
    check(walks - w0 == (miss ? 1 : 0), {tag, " walk count"}, walks - w0, miss ? 1 : 0);
  endtask

  task automatic write_base(input logic [19:0] b);
    @(negedge clk);
    base_we = 1'b1; base_v = b;
    #1 check(req_ready == 1'b0, "R8 ready low during base write", int'(req_ready), 0);
    @(posedge clk); #1;
    base_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    // process A table at 0x1000
    pt[32'h1000 + 3*2]  = 16'hF02A; // rwx
    pt[32'h1000 + 5*2]  = 16'h702B; // not valid, rights set
    pt[32'h1000 + 7*2]  = 16'h9011; // read only
    pt[32'h1000 + 9*2]  = 16'hC0C5; // execute only
    pt[32'h1000 + 11*2] = 16'hBC3F; // rw, reserved bits set
    // process B table at 0x2000
    pt[32'h2000 + 3*2]  = 16'hF033;
    for (int v = 20; v <= 27; v++) pt[32'h2000 + v*2] = 16'hF000 | 16'(v + 256);
    pt[32'h2000 + 40*2] = 16'hF2AA;

    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R10 reset ready", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R10 reset rsp_valid", int'(rsp_valid), 0);
    check(mem_req == 1'b0, "R10 reset mem_req", int'(mem_req), 0);
    rst_n = 1'b1;

    write_base(20'h01000);
    do_req({10'd3, 10'h155}, 2'b00, 1, "R1 load miss");
    check(last_addr == 32'h1006, "R2 entry address", last_addr, 32'h1006);
    do_req({10'd3, 10'h3FF}, 2'b01, 0, "R1 store hit offset");
    do_req({10'd3, 10'h000}, 2'b10, 0, "R4 fetch hit");

    do_req({10'd5, 10'h010}, 2'b00, 1, "R5 invalid page");
    do_req({10'd5, 10'h010}, 2'b00, 1, "R5 retry walks");

    do_req({10'd7, 10'h020}, 2'b00, 1, "R6 load read-only");
    do_req({10'd7, 10'h020}, 2'b01, 0, "R7 store read-only cached");
    do_req({10'd7, 10'h021}, 2'b11, 0, "R7 fetch read-only cached");
    do_req({10'd9, 10'h0AB}, 2'b10, 1, "R6 fetch exec-only");
    do_req({10'd9, 10'h0AB}, 2'b00, 0, "R6 load exec-only");

    do_req({10'd11, 10'h2C1}, 2'b01, 1, "R3 reserved bits ignored");
    check(last_addr == 32'h1016, "R2 entry address 11", last_addr, 32'h1016);

    write_base(20'h02000);
    do_req({10'd3, 10'h155}, 2'b00, 1, "R8 new space after base write");
    check(last_addr == 32'h2006, "R8 new base used", last_addr, 32'h2006);
    for (int v = 20; v <= 26; v++) do_req({10'(v), 10'h004}, 2'b00, 1, "R9 fill");
    do_req({10'd27, 10'h004}, 2'b01, 1, "R9 ninth page");
    do_req({10'd21, 10'h008}, 2'b10, 0, "R9 survivor hits");
    do_req({10'd3, 10'h100}, 2'b00, 1, "R9 first page evicted");
    do_req({10'd20, 10'h100}, 2'b00, 1, "R9 slot one evicted");

    fork
      do_req({10'd40, 10'h00F}, 2'b00, 1, "R11 walk with base write");
      begin
        repeat (2) @(negedge clk);
        base_we = 1'b1; base_v = 20'h02000;
        @(posedge clk); #1;
        base_we = 1'b0;
      end
    join
    do_req({10'd40, 10'h00F}, 2'b00, 1, "R11 entry not installed");
    do_req({10'd40, 10'h010}, 2'b01, 0, "R11 installed on clean walk");

    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R10 every request answered", sb_q.size(), 0);
    report();
  end
endmodule